// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by walking a radix tree of page tables four levels deep. A request carries the address and three access attributes: write, user mode and instruction fetch. The walker then fetches one 64-bit table entry per level over a request/response memory port. The first table comes from a root page number input. Each later table, and the final page, comes from the page number field held in the entry just read. Every table is 4 KB aligned and holds 512 entries of 8 bytes.

At each level the walker checks the entry. A missing page stops the walk with a page fault. A write through a read-only entry, a user access through a supervisor-only entry, or a fetch through a no-execute entry stops it with a protection fault. When the walk succeeds, the walker writes the last-level entry back to memory with its accessed flag set, and with its dirty flag set if the access was a write. It then reports the page number and the full physical address. The block handles one walk at a time and shows busy until it answers. Translation caching, large pages and fault handling by software belong to other blocks.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, mem_req_valid and done_valid are all 0.
- R2: The level-k read (k = 1..4) goes to address {table_ppn, idx_k, 3'b000}. idx_1 is vaddr[47:39], idx_2 is vaddr[38:30], idx_3 is vaddr[29:21] and idx_4 is vaddr[20:12]. The level-1 table_ppn is root_ppn, and each later table_ppn is bits [51:12] of the entry read at the level before.
- R3: An accepted request raises busy from the next cycle through the result cycle. While busy, req_valid is ignored. Each memory request stays asserted with a stable address until mem_rsp_valid. A successful walk makes exactly four reads and one write.
- R4: An entry whose bit 0 (present) is 0 ends the walk with done_fault = 1 (page fault). No further reads and no write follow.
- R5: A write access through any entry whose bit 1 (writable) is 0 ends the walk with done_fault = 2 (protection). A read through the same entries succeeds.
- R6: A user access (req_user = 1) through any entry whose bit 2 (user-accessible) is 0 ends the walk with done_fault = 2. A supervisor access through the same entries succeeds.
- R7: An instruction fetch (req_exec = 1) through any entry whose bit 63 (no-execute) is 1 ends the walk with done_fault = 2. A data read through the same entries succeeds.
- R8: If an entry fails both the present check and a permission check, the fault code is 1.
- R9: On success, the walker writes the last-level entry to its own address. Bit 5 (accessed) is set, bit 6 (dirty) is set if the access was a write, and all other bits are unchanged. A fault produces no write.
- R10: The result is a one-cycle done_valid pulse. On success, done_fault = 0, done_ppn = leaf bits [51:12] and done_paddr = {done_ppn, vaddr[11:0]}. On a fault, done_ppn and done_paddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| root_ppn | input | 40 | Page number of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request, held until response |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory completes the current request |
| mem_rsp_rdata | input | 64 | Entry value read |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| done_ppn | output | 40 | Translated page number |
| done_paddr | output | 52 | Translated physical address |

## Verification
The assertions check on every cycle the memory-port rules: entry addresses are aligned to 8 bytes, a request holds steady until its response, and no request goes out while idle. They also check that the write-back always carries the accessed flag, and the dirty flag on writes, that the result is a single pulse, and that a faulting result carries no address. Only the bench scenarios can show that the right slice of the address indexes each level, that the walk follows the page number from each entry, and that each permission bit and the present bit give the right fault at the right level. The same goes for the priority between the two fault kinds and the count of memory accesses each walk makes.

// File: rtl/pw_pkg.sv
package pw_pkg;
   localparam int unsigned BIT_PRESENT = 0;
   localparam int unsigned BIT_WRITABLE = 1;
   localparam int unsigned BIT_USER = 2;
   localparam int unsigned BIT_ACCESSED = 5;
   localparam int unsigned BIT_DIRTY = 6;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_PAGE = 2'd1,
      FLT_PROT = 2'd2
   } pw_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_READ   = 2'd1,
      ST_UPDATE = 2'd2,
      ST_DONE   = 2'd3
   } pw_state_e;
endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
   parameter int unsigned VA_W   = 48,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned LEVELS = 4,
   localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] level,
   output logic [IDX_W-1:0] index
);
   logic [IDX_W-1:0] slice [LEVELS];

   for (genvar k = 0; k < LEVELS; k++) begin : g_slice
      assign slice[k] = vaddr[OFF_W + (LEVELS-1-k)*IDX_W +: IDX_W];
   end

   always_comb begin
      index = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (level == LVL_W'(k)) index = slice[k];
      end
   end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check #(
   parameter int unsigned PTE_W  = 64,
   parameter bit          XD_EN  = 1'b1
) (
   input  logic [PTE_W-1:0] entry,
   input  logic             acc_write,
   input  logic             acc_user,
   input  logic             acc_exec,
   output logic             not_present,
   output logic             prot_fault
);
   import pw_pkg::*;
   logic exec_block;

   if (XD_EN) begin : g_xd
      assign exec_block = acc_exec & entry[PTE_W-1];
   end else begin : g_no_xd
      assign exec_block = 1'b0;
   end

   assign not_present = ~entry[BIT_PRESENT];
   assign prot_fault  = (acc_write & ~entry[BIT_WRITABLE])
                      | (acc_user & ~entry[BIT_USER])
                      | exec_block;
endmodule

// File: rtl/pw_flag_merge.sv
module pw_flag_merge #(
   parameter int unsigned PTE_W = 64
) (
   input  logic [PTE_W-1:0] leaf,
   input  logic             acc_write,
   output logic [PTE_W-1:0] updated
);
   import pw_pkg::*;
   always_comb begin
      updated = leaf;
      updated[BIT_ACCESSED] = 1'b1;
      if (acc_write) updated[BIT_DIRTY] = 1'b1;
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int unsigned VA_W   = 48,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned LEVELS = 4,
   parameter int unsigned PPN_W  = 40,
   parameter int unsigned PTE_W  = 64,
   parameter bit          XD_EN  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic                   req_write,
   input  logic                   req_user,
   input  logic                   req_exec,
   input  logic [PPN_W-1:0]       root_ppn,
   output logic                   busy,
   output logic                   mem_req_valid,
   output logic                   mem_req_write,
   output logic [PPN_W+OFF_W-1:0] mem_req_addr,
   output logic [PTE_W-1:0]       mem_req_wdata,
   input  logic                   mem_rsp_valid,
   input  logic [PTE_W-1:0]       mem_rsp_rdata,
   output logic                   done_valid,
   output logic [1:0]             done_fault,
   output logic [PPN_W-1:0]       done_ppn,
   output logic [PPN_W+OFF_W-1:0] done_paddr
);
   import pw_pkg::*;

   localparam int unsigned PA_W    = PPN_W + OFF_W;
   localparam int unsigned LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int unsigned ESZ_W   = $clog2(PTE_W / 8);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_bad_va
      $error("virtual width must equal offset plus all index slices");
   end
   if (OFF_W != IDX_W + ESZ_W) begin : g_bad_tbl
      $error("a table must fill exactly one page");
   end
   if (PA_W > PTE_W - 1) begin : g_bad_pte
      $error("entry too narrow for the page number field");
   end

   pw_state_e            state_q;
   logic [LVL_W-1:0]     lvl_q;
   logic [PPN_W-1:0]     base_q;
   logic [VA_W-1:0]      va_q;
   logic                 wr_q, us_q, ex_q;
   logic [PTE_W-1:0]     leaf_q;
   logic [PA_W-1:0]      leaf_addr_q;
   pw_fault_e            fault_q;
   logic [PPN_W-1:0]     ppn_q;

   logic [IDX_W-1:0]     idx;
   logic [PA_W-1:0]      walk_addr;
   logic                 chk_np, chk_prot;
   logic [PTE_W-1:0]     wb_data;

   pw_index_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx (
      .vaddr (va_q),
      .level (lvl_q),
      .index (idx)
   );

   pw_entry_check #(.PTE_W(PTE_W), .XD_EN(XD_EN)) u_chk_entry (
      .entry       (mem_rsp_rdata),
      .acc_write   (wr_q),
      .acc_user    (us_q),
      .acc_exec    (ex_q),
      .not_present (chk_np),
      .prot_fault  (chk_prot)
   );

   pw_flag_merge #(.PTE_W(PTE_W)) u_merge (
      .leaf      (leaf_q),
      .acc_write (wr_q),
      .updated   (wb_data)
   );

   assign walk_addr = {base_q, idx, {ESZ_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         lvl_q       <= '0;
         base_q      <= '0;
         va_q        <= '0;
         wr_q        <= 1'b0;
         us_q        <= 1'b0;
         ex_q        <= 1'b0;
         leaf_q      <= '0;
         leaf_addr_q <= '0;
         fault_q     <= FLT_NONE;
         ppn_q       <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_READ;
                  lvl_q   <= '0;
                  base_q  <= root_ppn;
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  us_q    <= req_user;
                  ex_q    <= req_exec;
                  fault_q <= FLT_NONE;
                  ppn_q   <= '0;
               end
            end
            ST_READ: begin
               if (mem_rsp_valid) begin
                  if (chk_np) begin
                     fault_q <= FLT_PAGE;
                     state_q <= ST_DONE;
                  end else if (chk_prot) begin
                     fault_q <= FLT_PROT;
                     state_q <= ST_DONE;
                  end else if (lvl_q == LAST_LVL) begin
                     leaf_q      <= mem_rsp_rdata;
                     leaf_addr_q <= walk_addr;
                     state_q     <= ST_UPDATE;
                  end else begin
                     base_q <= mem_rsp_rdata[OFF_W +: PPN_W];
                     lvl_q  <= lvl_q + 1'b1;
                  end
               end
            end
            ST_UPDATE: begin
               if (mem_rsp_valid) begin
                  ppn_q   <= leaf_q[OFF_W +: PPN_W];
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign mem_req_valid = (state_q == ST_READ) || (state_q == ST_UPDATE);
   assign mem_req_write = (state_q == ST_UPDATE);
   assign mem_req_addr  = (state_q == ST_UPDATE) ? leaf_addr_q : walk_addr;
   assign mem_req_wdata = (state_q == ST_UPDATE) ? wb_data : '0;
   assign done_valid    = (state_q == ST_DONE);
   assign done_fault    = done_valid ? fault_q : FLT_NONE;
   assign done_ppn      = (done_valid && fault_q == FLT_NONE) ? ppn_q : '0;
   assign done_paddr    = (done_valid && fault_q == FLT_NONE) ?
                          {ppn_q, va_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
   parameter int unsigned PA_W  = 52,
   parameter int unsigned PPN_W = 40,
   parameter int unsigned PTE_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             mem_req_valid,
   input logic             mem_req_write,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic [PTE_W-1:0] mem_req_wdata,
   input logic             mem_rsp_valid,
   input logic             done_valid,
   input logic [1:0]       done_fault,
   input logic [PPN_W-1:0] done_ppn,
   input logic [PA_W-1:0]  done_paddr,
   input logic             acc_write
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req_valid && !done_valid)); // R3
   AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R3
   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]); // R9
   AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && acc_write) |-> mem_req_wdata[6]); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R10
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault != 2'd0) |-> (done_ppn == '0 && done_paddr == '0)); // R10
   AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_fault != 2'd3)); // R10
endmodule

bind pt_walker pw_walker_chk #(
   .PA_W(PPN_W + OFF_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
) u_walker_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_rsp_valid (mem_rsp_valid),
   .done_valid    (done_valid),
   .done_fault    (done_fault),
   .done_ppn      (done_ppn),
   .done_paddr    (done_paddr),
   .acc_write     (wr_q)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [47:0] req_vaddr = '0;
   logic        req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
   logic [39:0] root_ppn = 40'h100;
   logic        busy, mem_req_valid, mem_req_write;
   logic [51:0] mem_req_addr;
   logic [63:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_rdata = '0;
   logic        done_valid;
   logic [1:0]  done_fault;
   logic [39:0] done_ppn;
   logic [51:0] done_paddr;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   pt_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .req_exec(req_exec),
      .root_ppn(root_ppn), .busy(busy), .mem_req_valid(mem_req_valid),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
      .done_fault(done_fault), .done_ppn(done_ppn), .done_paddr(done_paddr)
   );

   // memory model
   logic [63:0] mem [logic [51:0]];
   int          rd_cnt, wr_cnt, lat_cnt;
   logic [51:0] rd_log [8];
   logic [51:0] last_waddr;
   logic [63:0] last_wdata;

   initial begin
      lat_cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
         end else if (mem_req_valid) begin
            if (lat_cnt == 2) begin
               lat_cnt = 0;
               if (mem_req_write) begin
                  mem[mem_req_addr] = mem_req_wdata;
                  last_waddr = mem_req_addr;
                  last_wdata = mem_req_wdata;
                  wr_cnt++;
               end else begin
                  mem_rsp_rdata = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                  if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
                  rd_cnt++;
               end
               mem_rsp_valid = 1'b1;
            end else begin
               lat_cnt++;
            end
         end
      end
   end

   // table layout used by every scenario
   logic [39:0] tbl [4];
   logic [11:0] lo  [4];
   logic        xd  [4];
   localparam logic [39:0] LEAF_PPN = 40'hAB_CDE1_2345;

   function automatic logic [63:0] mk_pte(logic [39:0] ppn, logic [11:0] low, logic x);
      return {x, 11'h0, ppn, low};
   endfunction

   function automatic logic [8:0] idx_of(logic [47:0] va, int k);
      return va[12 + (3-k)*9 +: 9];
   endfunction

   function automatic logic [51:0] ent_addr(logic [47:0] va, int k);
      return {tbl[k], idx_of(va, k), 3'b000};
   endfunction

   task automatic build(logic [47:0] va);
      mem.delete();
      tbl[0] = root_ppn; tbl[1] = 40'h200; tbl[2] = 40'h300; tbl[3] = 40'h400;
      for (int k = 0; k < 4; k++) begin
         mem[ent_addr(va, k)] = mk_pte((k == 3) ? LEAF_PPN : tbl[k+1], lo[k], xd[k]);
      end
   endtask

   task automatic set_all(logic [11:0] v);
      for (int k = 0; k < 4; k++) begin
         lo[k] = v; xd[k] = 1'b0;
      end
   endtask

   task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [1:0]  r_fault;
   logic [39:0] r_ppn;
   logic [51:0] r_paddr;

   task automatic walk(logic [47:0] va, logic w, logic u, logic x);
      int n;
      rd_cnt = 0; wr_cnt = 0;
      @(negedge clk);
      req_vaddr = va; req_write = w; req_user = u; req_exec = x; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      r_fault = done_fault; r_ppn = done_ppn; r_paddr = done_paddr;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check(!busy && !mem_req_valid && !done_valid, "R1 reset outputs",
            {busy, mem_req_valid, done_valid}, 0);
   endtask

   task automatic t_read_ok;
      logic [47:0] va = 48'h8F3A_5C6B_7123;
      logic [63:0] leaf;
      set_all(12'h001);
      build(va);
      leaf = mem[ent_addr(va, 3)];
      walk(va, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++)
         check(rd_log[k] == ent_addr(va, k), "R2 entry address", rd_log[k], ent_addr(va, k));
      check(rd_cnt == 4 && wr_cnt == 1, "R3 access count", rd_cnt*16 + wr_cnt, 65);
      check(r_fault == 0, "R10 fault code", r_fault, 0);
      check(r_ppn == LEAF_PPN, "R10 ppn", r_ppn, LEAF_PPN);
      check(r_paddr == {LEAF_PPN, va[11:0]}, "R10 paddr", r_paddr, {LEAF_PPN, va[11:0]});
      check(last_waddr == ent_addr(va, 3), "R9 writeback addr", last_waddr, ent_addr(va, 3));
      check(last_wdata == (leaf | 64'h20), "R9 accessed only", last_wdata, leaf | 64'h20);
   endtask

   task automatic t_write_ok;
      logic [47:0] va = 48'h0123_4567_89AB;
      logic [63:0] leaf;
      set_all(12'h007);
      lo[3] = 12'h117;
      build(va);
      leaf = mem[ent_addr(va, 3)];
      walk(va, 1'b1, 1'b1, 1'b0);
      check(r_fault == 0, "R9 user write ok", r_fault, 0);
      check(last_wdata == (leaf | 64'h60), "R9 accessed and dirty", last_wdata, leaf | 64'h60);
   endtask

   task automatic t_busy_ignore;
      logic [47:0] va = 48'hFFFF_0000_1FFF;
      int n;
      set_all(12'h001);
      build(va);
      rd_cnt = 0; wr_cnt = 0;
      @(negedge clk);
      req_vaddr = va; req_write = 0; req_user = 0; req_exec = 0; req_valid = 1'b1;
      @(negedge clk);
      req_vaddr = 48'h0000_1111_2222;
      check(busy, "R3 busy after accept", busy, 1);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done_valid && n < 200) begin
         check(busy, "R3 busy during walk", busy, 1);
         @(negedge clk); n++;
      end
      check(done_valid && busy, "R3 busy at result", {done_valid, busy}, 3);
      check(done_paddr == {LEAF_PPN, va[11:0]}, "R3 later request ignored",
            done_paddr, {LEAF_PPN, va[11:0]});
      @(negedge clk);
      check(!busy && !done_valid, "R10 one-cycle result", {busy, done_valid}, 0);
      check(rd_cnt == 4 && wr_cnt == 1, "R3 single walk", rd_cnt*16 + wr_cnt, 65);
   endtask

   task automatic t_not_present;
      logic [47:0] va = 48'h7654_3210_FEDC;
      set_all(12'h007);
      lo[2] = 12'h006;
      build(va);
      walk(va, 1'b0, 1'b0, 1'b0);
      check(r_fault == 1, "R4 page fault", r_fault, 1);
      check(rd_cnt == 3 && wr_cnt == 0, "R4 stops walk", rd_cnt*16 + wr_cnt, 48);
      check(r_ppn == 0 && r_paddr == 0, "R10 no address on fault", r_paddr, 0);
   endtask

   task automatic t_priority;
      logic [47:0] va = 48'h1357_9BDF_0246;
      set_all(12'h007);
      lo[1] = 12'h000;
      build(va);
      walk(va, 1'b1, 1'b1, 1'b0);
      check(r_fault == 1, "R8 present wins", r_fault, 1);
   endtask

   task automatic t_readonly;
      logic [47:0] va = 48'h2468_ACE0_1357;
      set_all(12'h007);
      lo[1] = 12'h005;
      build(va);
      walk(va, 1'b1, 1'b0, 1'b0);
      check(r_fault == 2, "R5 write to read-only", r_fault, 2);
      check(wr_cnt == 0 && rd_cnt == 2, "R5 no writeback", rd_cnt*16 + wr_cnt, 32);
      walk(va, 1'b0, 1'b0, 1'b0);
      check(r_fault == 0, "R5 read allowed", r_fault, 0);
   endtask

   task automatic t_user;
      logic [47:0] va = 48'h0F0F_F0F0_0AAA;
      set_all(12'h007);
      lo[3] = 12'h003;
      build(va);
      walk(va, 1'b0, 1'b1, 1'b0);
      check(r_fault == 2, "R6 user denied", r_fault, 2);
      walk(va, 1'b0, 1'b0, 1'b0);
      check(r_fault == 0, "R6 supervisor allowed", r_fault, 0);
   endtask

   task automatic t_exec;
      logic [47:0] va = 48'h5A5A_A5A5_0555;
      set_all(12'h007);
      xd[0] = 1'b1;
      build(va);
      walk(va, 1'b0, 1'b0, 1'b1);
      check(r_fault == 2, "R7 fetch blocked", r_fault, 2);
      check(rd_cnt == 1, "R7 stops at first level", rd_cnt, 1);
      walk(va, 1'b0, 1'b0, 1'b0);
      check(r_fault == 0, "R7 data read allowed", r_fault, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rd_cnt = 0; wr_cnt = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_ok();
      t_write_ok();
      t_busy_ignore();
      t_not_present();
      t_priority();
      t_readonly();
      t_user();
      t_exec();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule